// File: doc/BRIEF.md
# SD Host Interrupt and Status Unit

This block collects the event and level information of an SD/MMC host controller and turns it into one interrupt line toward the CPU. The command/response engine and the data engine report their events as single-cycle pulses. The block latches each pulse into a sticky bit of a byte-wide status register. The CPU reads these bits and clears them by writing ones. Two byte-wide enable registers select which sticky bits may raise the interrupt. A global enable in a 16-bit configuration register gates the whole output.

The card-detect and write-protect pins are asynchronous to the block clock. Each pin goes through a multi-stage synchronizer. The two card-detect candidates (a general-purpose input pin and the DAT3 line) are also debounced. A configuration bit picks which candidate is the card-detect source, and another bit gives its active polarity. A change of the chosen debounced level sets a sticky "card change" bit. A change into the present state also sets a "card arrived" bit.

All registers sit behind a simple byte-addressed port: a write strobe with address and data, and a combinational read bus. A synchronous soft-reset input returns the sticky bits and the enable bits to zero.

Top module: `sd_irq_status_unit`

## Requirements
- R1: After `rst_n` is released, every register reads 0 when all pins are held low. This covers status byte 0 (address 0), status byte 1 (1), status byte 2 (2), enable byte 0 (3), enable byte 1 (4), reserved (5) and the configuration bytes (6 low, 7 high). `irq` and `clk_freeze_en` are also 0.
- R2: A pulse on `evt_host[k]` sets status byte 1 bit k. The bit reads 1 from the next cycle on and stays set until it is cleared. The bit positions are: 0 SDIO, 1 command done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC error, 6 read CRC error, 7 write CRC error.
- R3: A write to a status byte clears exactly the sticky bits written as 1. A bit written as 0 keeps its value, and a write of 0 leaves the byte unchanged. The sticky bits of status byte 0 are bits 7..4.
- R4: If an event and a clearing write hit the same sticky bit in the same cycle, the bit stays set.
- R5: A pulse on `evt_blk_done` sets status byte 0 bit 5. A pulse on `evt_mblk_done` sets status byte 0 bit 4.
- R6: Enable byte 1 stores bits 7..1, and enable byte 0 stores bits 7..4. All other enable bits read 0. `irq` is high exactly when the global enable is set and some sticky bit is set together with its enable bit. Because of this, the SDIO bit (status byte 1 bit 0) never raises `irq`.
- R7: The configuration register stores bits 15, 13, 12 and 10..0, and its other bits read 0. Bit 15 (bit 7 of address 7) is the global enable. While it is 0, `irq` stays low.
- R8: Status byte 0 shows level bits that are not sticky: bit 1 is the synchronized write-protect pin, bit 2 the debounced DAT3 level, and bit 3 the debounced GPI level. A write does not change them, and they never raise `irq`.
- R9: A card-detect pin change becomes visible only after the synchronized level has differed from the debounced level for `DEBOUNCE_CYCLES` consecutive cycles. A shorter pulse leaves no trace.
- R10: Configuration bit 13 picks the card-detect source (1 = GPI pin, 0 = DAT3). Bit 12 picks the polarity (1 = present when high, 0 = present when low). When the selected debounced level changes, status byte 0 bit 7 is set. When the new level is the present state, bit 6 is also set. A change on the pin that is not selected sets neither bit.
- R11: Status byte 2 shows `cmd_busy` at bit 4 and `data_busy` at bit 5 as live levels, and writes to these bits have no effect. Bit 7 is read/write and drives `clk_freeze_en`.
- R12: `soft_rst` clears all sticky status bits and all enable bits, even when an event arrives in the same cycle. The configuration register and status byte 2 bit 7 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of sticky and enable bits |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| evt_host | input | 8 | Event pulses at status byte 1 bit positions |
| evt_blk_done | input | 1 | Block done pulse |
| evt_mblk_done | input | 1 | Multi-block done pulse |
| cmd_busy | input | 1 | Command engine busy level |
| data_busy | input | 1 | Data engine busy level |
| wp_pin | input | 1 | Write-protect pin, asynchronous |
| dat3_pin | input | 1 | DAT3 card-detect pin, asynchronous |
| gpi_pin | input | 1 | GPI card-detect pin, asynchronous |
| clk_freeze_en | output | 1 | Automatic clock-freeze enable |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
The bench builds the unit with `DEBOUNCE_CYCLES` = 3, `SYNC_STAGES` = 2 and `ADDR_W` = 3. The short debounce window lets the bench drive pin pulses of two and three cycles, one on each side of the acceptance boundary, within a few clock cycles. The 3-bit address reaches every register, so the bench sweeps all 256 values of each enable byte and all 256 clear patterns of status byte 1, and predicts each result by bitwise arithmetic.

// File: rtl/sdis_pkg.sv
package sdis_pkg;
   // register byte addresses
   localparam int unsigned ADR_STAT0 = 0;
   localparam int unsigned ADR_STAT1 = 1;
   localparam int unsigned ADR_STAT2 = 2;
   localparam int unsigned ADR_ENA0  = 3;
   localparam int unsigned ADR_ENA1  = 4;
   localparam int unsigned ADR_CFGL  = 6;
   localparam int unsigned ADR_CFGH  = 7;

   // writable / sticky bit masks
   localparam logic [7:0]  STICKY0_MASK = 8'hF0;
   localparam logic [7:0]  STICKY1_MASK = 8'hFF;
   localparam logic [7:0]  ENA0_MASK    = 8'hF0;
   localparam logic [7:0]  ENA1_MASK    = 8'hFE;
   localparam logic [15:0] CFG_MASK     = 16'hB7FF;

   // configuration bit positions
   localparam int unsigned CFG_GIE    = 15;
   localparam int unsigned CFG_GPISEL = 13;
   localparam int unsigned CFG_POLHI  = 12;

   // status byte 0 positions
   localparam int unsigned S0_WP     = 1;
   localparam int unsigned S0_DAT3   = 2;
   localparam int unsigned S0_GPI    = 3;
   localparam int unsigned S0_MBLK   = 4;
   localparam int unsigned S0_BLK    = 5;
   localparam int unsigned S0_ARRIVE = 6;
   localparam int unsigned S0_CHANGE = 7;

   // status byte 2 positions
   localparam int unsigned S2_CBUSY  = 4;
   localparam int unsigned S2_DBUSY  = 5;
   localparam int unsigned S2_FREEZE = 7;

   typedef enum logic [0:0] {CD_DAT3 = 1'b0, CD_GPI = 1'b1} cd_src_e;
endpackage

// File: rtl/sdis_sync.sv
module sdis_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sdis_debounce.sv
module sdis_debounce #(
   parameter int unsigned DEBOUNCE_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int unsigned CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'((DEBOUNCE_CYCLES > 0) ? DEBOUNCE_CYCLES - 1 : 0);

   generate
      if (DEBOUNCE_CYCLES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_filter
         logic          stable_q;
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stable_q <= 1'b0;
               cnt_q    <= '0;
            end else if (d == stable_q) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               stable_q <= d;
               cnt_q    <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign q = stable_q;
      end
   endgenerate
endmodule

// File: rtl/sdis_sticky_byte.sv
module sdis_sticky_byte #(
   parameter logic [7:0] KEEP_MASK = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic [7:0] set_bits,
   input  logic [7:0] clr_bits,
   output logic [7:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (soft_rst) q <= '0;
      else               q <= ((q & ~clr_bits) | set_bits) & KEEP_MASK;
   end
endmodule

// File: rtl/sd_irq_status_unit.sv
module sd_irq_status_unit
   import sdis_pkg::*;
#(
   parameter int unsigned ADDR_W          = 3,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned DEBOUNCE_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [7:0]        evt_host,
   input  logic              evt_blk_done,
   input  logic              evt_mblk_done,
   input  logic              cmd_busy,
   input  logic              data_busy,
   input  logic              wp_pin,
   input  logic              dat3_pin,
   input  logic              gpi_pin,
   output logic              clk_freeze_en,
   output logic              irq
);
   localparam int unsigned NPINS = 3;
   localparam int unsigned NCD   = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
   endgenerate

   // pin synchronization and debounce
   logic [NPINS-1:0] pins_s;
   logic [NCD-1:0]   cd_raw, cd_db;

   sdis_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({gpi_pin, dat3_pin, wp_pin}),
      .q    (pins_s)
   );

   assign cd_raw = pins_s[2:1];

   generate
      for (genvar p = 0; p < NCD; p++) begin : g_cd
         sdis_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) i_db (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (cd_raw[p]),
            .q    (cd_db[p])
         );
      end
   endgenerate

   logic wp_s, dat3_db, gpi_db;
   assign wp_s    = pins_s[0];
   assign dat3_db = cd_db[0];
   assign gpi_db  = cd_db[1];

   // configuration and enable registers
   logic [15:0] cfg_q;
   logic [7:0]  ena0_q, ena1_q;
   logic        freeze_q;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned target);
      return a == ADDR_W'(target);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         freeze_q <= 1'b0;
      end else if (wr_en) begin
         if (hit(addr, ADR_CFGL)) cfg_q[7:0]  <= wdata & CFG_MASK[7:0];
         if (hit(addr, ADR_CFGH)) cfg_q[15:8] <= wdata & CFG_MASK[15:8];
         if (hit(addr, ADR_STAT2)) freeze_q   <= wdata[S2_FREEZE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena0_q <= '0;
         ena1_q <= '0;
      end else if (soft_rst) begin
         ena0_q <= '0;
         ena1_q <= '0;
      end else if (wr_en) begin
         if (hit(addr, ADR_ENA0)) ena0_q <= wdata & ENA0_MASK;
         if (hit(addr, ADR_ENA1)) ena1_q <= wdata & ENA1_MASK;
      end
   end

   // card-detect change tracking
   cd_src_e cd_src;
   logic    cd_level, cd_prev_q, cd_change, cd_arrive;

   assign cd_src    = cd_src_e'(cfg_q[CFG_GPISEL]);
   assign cd_level  = (cd_src == CD_GPI) ? gpi_db : dat3_db;
   assign cd_change = cd_level != cd_prev_q;
   assign cd_arrive = cd_change && (cd_level == cfg_q[CFG_POLHI]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cd_prev_q <= 1'b0;
      else        cd_prev_q <= cd_level;
   end

   // sticky status bytes
   logic [7:0] set0, set1, clr0, clr1, st0_q, st1_q;

   always_comb begin
      set0            = '0;
      set0[S0_MBLK]   = evt_mblk_done;
      set0[S0_BLK]    = evt_blk_done;
      set0[S0_ARRIVE] = cd_arrive;
      set0[S0_CHANGE] = cd_change;
      set1            = evt_host;
      clr0 = (wr_en && hit(addr, ADR_STAT0)) ? (wdata & STICKY0_MASK) : 8'h00;
      clr1 = (wr_en && hit(addr, ADR_STAT1)) ? (wdata & STICKY1_MASK) : 8'h00;
   end

   sdis_sticky_byte #(.KEEP_MASK(STICKY0_MASK)) i_stat0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .set_bits(set0), .clr_bits(clr0), .q(st0_q)
   );

   sdis_sticky_byte #(.KEEP_MASK(STICKY1_MASK)) i_stat1 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .set_bits(set1), .clr_bits(clr1), .q(st1_q)
   );

   // read view
   logic [7:0] stat0_view, stat2_view;

   always_comb begin
      stat0_view            = st0_q;
      stat0_view[S0_WP]     = wp_s;
      stat0_view[S0_DAT3]   = dat3_db;
      stat0_view[S0_GPI]    = gpi_db;
      stat2_view            = '0;
      stat2_view[S2_CBUSY]  = cmd_busy;
      stat2_view[S2_DBUSY]  = data_busy;
      stat2_view[S2_FREEZE] = freeze_q;
   end

   always_comb begin
      rdata = 8'h00;
      if (hit(addr, ADR_STAT0)) rdata = stat0_view;
      if (hit(addr, ADR_STAT1)) rdata = st1_q;
      if (hit(addr, ADR_STAT2)) rdata = stat2_view;
      if (hit(addr, ADR_ENA0))  rdata = ena0_q;
      if (hit(addr, ADR_ENA1))  rdata = ena1_q;
      if (hit(addr, ADR_CFGL))  rdata = cfg_q[7:0];
      if (hit(addr, ADR_CFGH))  rdata = cfg_q[15:8];
   end

   assign clk_freeze_en = freeze_q;
   assign irq = cfg_q[CFG_GIE] & (|((st0_q & ena0_q) | (st1_q & ena1_q)));
endmodule

// File: rtl/sdis_checker.sv
module sdis_checker #(
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        evt_host,
   input logic [7:0]        st0_q,
   input logic [7:0]        st1_q,
   input logic [7:0]        ena1_q,
   input logic [15:0]       cfg_q,
   input logic              irq
);
   logic wr_s1;
   assign wr_s1 = wr_en && (addr == ADDR_W'(1));

   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && evt_host != 8'h00) |=> ((st1_q & $past(evt_host)) == $past(evt_host)));

   assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && !wr_s1 && evt_host == 8'h00) |=> (st1_q == $past(st1_q)));

   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && wr_s1 && evt_host == 8'h00) |=> ((st1_q & $past(wdata)) == 8'h00));

   assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && wr_s1 && evt_host != 8'h00) |=> ((st1_q & $past(evt_host)) == $past(evt_host)));

   assert_gie_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[15] |-> !irq);

   assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (st1_q == 8'h00 && st0_q == 8'h00 && ena1_q == 8'h00));
endmodule

bind sd_irq_status_unit sdis_checker #(.ADDR_W(ADDR_W)) i_sdis_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .soft_rst(soft_rst),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .evt_host(evt_host),
   .st0_q   (st0_q),
   .st1_q   (st1_q),
   .ena1_q  (ena1_q),
   .cfg_q   (cfg_q),
   .irq     (irq)
);

// File: tb/test_sd_irq_status_unit.sv
module test_sd_irq_status_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic [7:0]    evt_host = '0;
   logic          evt_blk_done = 1'b0;
   logic          evt_mblk_done = 1'b0;
   logic          cmd_busy = 1'b0;
   logic          data_busy = 1'b0;
   logic          wp_pin = 1'b0;
   logic          dat3_pin = 1'b0;
   logic          gpi_pin = 1'b0;
   logic          clk_freeze_en;
   logic          irq;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sd_irq_status_unit #(.ADDR_W(AW), .SYNC_STAGES(2), .DEBOUNCE_CYCLES(3)) i_sd_irq_status_unit (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_host(evt_host), .evt_blk_done(evt_blk_done),
      .evt_mblk_done(evt_mblk_done), .cmd_busy(cmd_busy), .data_busy(data_busy),
      .wp_pin(wp_pin), .dat3_pin(dat3_pin), .gpi_pin(gpi_pin),
      .clk_freeze_en(clk_freeze_en), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse_host(input logic [7:0] v);
      @(negedge clk);
      evt_host = v;
      @(negedge clk);
      evt_host = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset values
      for (int a = 0; a < 8; a++) begin
         rd(AW'(a), v);
         check("R1 reset read", v, 8'h00);
      end
      check("R1 irq", {7'b0, irq}, 8'h00);
      check("R1 freeze", {7'b0, clk_freeze_en}, 8'h00);

      // R2 each host event, R3 full clear
      for (int k = 0; k < 8; k++) begin
         pulse_host(8'h01 << k);
         idle(2);
         rd(3'd1, v);
         check("R2 event sets bit", v, 8'h01 << k);
         wr(3'd1, 8'hFF);
         rd(3'd1, v);
         check("R3 clear all", v, 8'h00);
      end

      // R3 sweep of clear patterns
      for (int d = 0; d < 256; d++) begin
         pulse_host(8'hFF);
         wr(3'd1, 8'(d));
         rd(3'd1, v);
         check("R3 partial clear", v, ~8'(d));
         wr(3'd1, 8'hFF);
      end

      // R4 event beats clear
      @(negedge clk);
      addr = 3'd1; wdata = 8'hFF; wr_en = 1'b1; evt_host = 8'h24;
      @(negedge clk);
      wr_en = 1'b0; evt_host = '0;
      rd(3'd1, v);
      check("R4 event wins", v, 8'h24);
      wr(3'd1, 8'hFF);

      // R5 block events
      @(negedge clk); evt_blk_done = 1'b1;
      @(negedge clk); evt_blk_done = 1'b0;
      rd(3'd0, v);
      check("R5 block done", v, 8'h20);
      @(negedge clk); evt_mblk_done = 1'b1;
      @(negedge clk); evt_mblk_done = 1'b0;
      rd(3'd0, v);
      check("R5 multi-block done", v, 8'h30);
      wr(3'd0, 8'h10);
      rd(3'd0, v);
      check("R3 status0 partial clear", v, 8'h20);
      wr(3'd0, 8'h00);
      rd(3'd0, v);
      check("R3 write zero no change", v, 8'h20);
      wr(3'd0, 8'hFF);

      // R7 configuration storage
      wr(3'd6, 8'h5A);
      rd(3'd6, v);
      check("R7 cfg low", v, 8'h5A);
      wr(3'd7, 8'hFF);
      rd(3'd7, v);
      check("R7 cfg high mask", v, 8'hB7);
      wr(3'd6, 8'h00);
      wr(3'd7, 8'h80);

      // R6 enable byte 1 sweep
      pulse_host(8'hFF);
      for (int m = 0; m < 256; m++) begin
         wr(3'd4, 8'(m));
         rd(3'd4, v);
         check("R6 ena1 readback", v, 8'(m) & 8'hFE);
         check("R6 irq from status1", {7'b0, irq}, {7'b0, |(8'(m) & 8'hFE)});
      end
      wr(3'd7, 8'h00);
      check("R7 gie off", {7'b0, irq}, 8'h00);
      wr(3'd7, 8'h80);
      wr(3'd1, 8'hFF);
      pulse_host(8'h01);
      check("R6 sdio no irq", {7'b0, irq}, 8'h00);
      wr(3'd1, 8'hFF);
      wr(3'd4, 8'h00);

      // R6 enable byte 0 sweep
      @(negedge clk); evt_blk_done = 1'b1; evt_mblk_done = 1'b1;
      @(negedge clk); evt_blk_done = 1'b0; evt_mblk_done = 1'b0;
      for (int m = 0; m < 256; m++) begin
         wr(3'd3, 8'(m));
         rd(3'd3, v);
         check("R6 ena0 readback", v, 8'(m) & 8'hF0);
         check("R6 irq from status0", {7'b0, irq}, {7'b0, |(8'(m) & 8'h30)});
      end
      wr(3'd3, 8'h00);
      wr(3'd0, 8'hFF);
      wr(3'd7, 8'h20);   // GPI source, active low, gie off

      // R8 level bits
      wp_pin = 1'b1;
      idle(4);
      rd(3'd0, v);
      check("R8 write-protect level", v, 8'h02);
      dat3_pin = 1'b1;
      idle(10);
      rd(3'd0, v);
      check("R10 unselected pin no event", v, 8'h06);

      // R9 glitch of two cycles rejected
      @(negedge clk); gpi_pin = 1'b1;
      idle(2); gpi_pin = 1'b0;
      idle(10);
      rd(3'd0, v);
      check("R9 short glitch ignored", v, 8'h06);

      // R9 boundary: three cycles accepted, then release
      @(negedge clk); gpi_pin = 1'b1;
      idle(3); gpi_pin = 1'b0;
      idle(12);
      rd(3'd0, v);
      check("R9 R10 boundary pulse events", v, 8'hC6);
      wr(3'd0, 8'hFF);
      rd(3'd0, v);
      check("R8 levels survive clear", v, 8'h06);
      wr(3'd3, 8'hFF);
      wr(3'd7, 8'hA0);
      check("R8 levels no irq", {7'b0, irq}, 8'h00);

      // R10 active-high polarity, arrival
      wr(3'd7, 8'hB0);
      idle(2);
      rd(3'd0, v);
      check("R10 polarity write no event", v, 8'h06);
      gpi_pin = 1'b1;
      idle(10);
      rd(3'd0, v);
      check("R10 arrival active high", v, 8'hCE);
      check("R6 irq on card event", {7'b0, irq}, 8'h01);
      wr(3'd0, 8'hFF);

      // R10 switch to DAT3 source, removal
      wr(3'd7, 8'h90);
      idle(2);
      rd(3'd0, v);
      check("R10 source switch same level", v, 8'h0E);
      dat3_pin = 1'b0;
      idle(10);
      rd(3'd0, v);
      check("R10 removal change only", v, 8'h8A);
      wr(3'd0, 8'hFF);
      wr(3'd3, 8'h00);

      // R11 status byte 2
      cmd_busy = 1'b1;
      rd(3'd2, v);
      check("R11 cmd busy", v, 8'h10);
      data_busy = 1'b1;
      rd(3'd2, v);
      check("R11 data busy", v, 8'h30);
      wr(3'd2, 8'hFF);
      rd(3'd2, v);
      check("R11 freeze bit", v, 8'hB0);
      check("R11 freeze output", {7'b0, clk_freeze_en}, 8'h01);
      cmd_busy = 1'b0; data_busy = 1'b0;
      wr(3'd2, 8'h80);
      rd(3'd2, v);
      check("R11 busy writes ignored", v, 8'h80);

      // R12 soft reset
      wr(3'd4, 8'hFE);
      wr(3'd3, 8'hF0);
      pulse_host(8'hF0);
      @(negedge clk); evt_blk_done = 1'b1;
      @(negedge clk); evt_blk_done = 1'b0;
      @(negedge clk); soft_rst = 1'b1; evt_host = 8'h02;
      @(negedge clk); soft_rst = 1'b0; evt_host = 8'h00;
      rd(3'd1, v);
      check("R12 status1 cleared", v, 8'h00);
      rd(3'd0, v);
      check("R12 status0 sticky cleared", v & 8'hF0, 8'h00);
      rd(3'd4, v);
      check("R12 ena1 cleared", v, 8'h00);
      rd(3'd3, v);
      check("R12 ena0 cleared", v, 8'h00);
      rd(3'd7, v);
      check("R12 cfg kept", v, 8'h90);
      rd(3'd2, v);
      check("R12 freeze kept", v, 8'h80);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule